// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Request-to-Send

This block is the receiving side of a clock-synchronous serial port. The shift clock is not generated here. It arrives on a pin from the transmitting side. The transmitter runs only after software writes a byte, possibly a dummy one, into the transmit buffer register. On each rising edge of the shift clock the block takes one bit from the serial data pin. After eight bits it moves the assembled byte into a receive buffer, sets a receive-complete flag and raises an interrupt request.

The block drives an active-low request-to-send line. The line tells the far side that a reception may start. It is released as soon as the first bit of a byte is taken. Status reports an overrun when a new byte lands in the buffer while the previous one is still unread. A control bit selects whether the first received bit lands in the least or the most significant position of the buffer.

Software reaches the block through a plain register port: one write strobe, one read strobe, a two-bit address and a combinational read-data bus. The port carries no stream and has no back-pressure. A byte that is not read in time is overwritten and the overrun is flagged instead.

Register map (ADDR): 0 control (bit 0 enable, bit 1 first-bit-at-MSB, bit 2 serial mode; 0 = parallel port), 1 transmit buffer (write only, the data is discarded), 2 receive buffer (a read clears receive-complete), 3 status (bit 0 receive-complete, bit 1 overrun, bits 4:2 async error flags, bit 5 transmit-buffer-empty, bit 6 interrupt request). A write to address 3 with bit 6 set acknowledges the interrupt request.

Top module: `sync_rx_port`

## Requirements
- R1: After reset, rts_n_o is 1, irq_o is 0, control reads 0 and status reads 0x20 (only transmit-buffer-empty set).
- R2: While the enable bit is 0, shift-clock edges shift in no bits, no byte completes and rts_n_o stays 1.
- R3: rts_n_o goes low once enable is 1, transmit-buffer-empty is 0 and no byte is in progress. It returns high when the first bit of a byte is accepted. Edges that arrive while rts_n_o is high and no byte is in progress are ignored.
- R4: A write to address 1 clears transmit-buffer-empty (status bit 5). The flag is set again when a byte completes.
- R5: Each rising edge of sclk_i, seen after a two-stage synchroniser, samples sdata_i. The eighth accepted bit copies the byte into the receive buffer (address 2) and sets receive-complete (status bit 0).
- R6: A 0-to-1 change of receive-complete sets the interrupt request (irq_o, status bit 6). The request stays set until a write to address 3 with bit 6 set.
- R7: A byte that completes while receive-complete is 1 sets overrun (status bit 1).
- R8: Receive-complete clears on a read of address 2, or while enable is 0.
- R9: Overrun is cleared only while enable is 0 or while serial mode (control bit 2) is 0. A buffer read leaves it set.
- R10: With control bit 1 at 0, the first received bit lands in buffer bit 0. With it at 1, the first bit lands in buffer bit 7.
- R11: Status bits 4:2 always read 0.
- R12: Clearing enable in the middle of a byte discards the bits collected so far. The next byte starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| sclk_i | input | 1 | Shift clock from the transmitter, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| rts_n_o | output | 1 | Active-low request-to-send |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its default values: eight data bits, two synchroniser stages and a two-bit address. With eight data bits, full bytes complete in both bit orders, and the bench can let a second byte land on an unread one to reach overrun. Two synchroniser stages plus the edge flop give a fixed three-cycle delay from a shift-clock rise to the accepted bit. The bench's cycle model repeats that delay, so it follows request-to-send and the interrupt edge on the exact cycle they change.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  // register addresses
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_TXB  = 1;
  localparam int unsigned ADR_RXB  = 2;
  localparam int unsigned ADR_STAT = 3;
  // control bit positions
  localparam int unsigned CB_EN  = 0;
  localparam int unsigned CB_MSB = 1;
  localparam int unsigned CB_SER = 2;
  // status bit positions
  localparam int unsigned SB_DONE = 0;
  localparam int unsigned SB_OVR  = 1;
  localparam int unsigned SB_TXE  = 5;
  localparam int unsigned SB_IRQ  = 6;
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              msb_first,
  output logic              idle,
  output logic              done_stb,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned CW = $clog2(DATA_W);

  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] nxt;
  logic              last;

  always_comb begin
    if (msb_first) nxt = {sh[DATA_W-2:0], bit_val};
    else           nxt = {bit_val, sh[DATA_W-1:1]};
  end

  assign last     = (cnt == CW'(DATA_W-1));
  assign idle     = (cnt == '0);
  assign done_stb = bit_stb & last;
  assign byte_o   = nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (bit_stb) begin
      cnt <= last ? '0 : cnt + 1'b1;
      sh  <= nxt;
    end
  end
endmodule

// File: rtl/sync_rx_port.sv
module sync_rx_port
  import sync_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,  // at least 8: status uses bits up to 6
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              rts_n_o,
  output logic              irq_o
);
  logic              en, msb_first, serial;
  logic              tx_empty, rx_done, overrun;
  logic [DATA_W-1:0] rx_buf;
  logic              sclk_s, sclk_q, sdata_s, rise;
  logic              accept, idle, complete;
  logic [DATA_W-1:0] byte_w;
  logic              wr_ctrl, wr_txb, wr_stat, rd_rxb;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(ADR_CTRL));
  assign wr_txb  = wr_en && (addr == ADDR_W'(ADR_TXB));
  assign wr_stat = wr_en && (addr == ADDR_W'(ADR_STAT));
  assign rd_rxb  = rd_en && (addr == ADDR_W'(ADR_RXB));

  // pin synchronisers and rising-edge detection
  sync_rx_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_s));
  sync_rx_sync #(.STAGES(SYNC_STAGES)) u_sdat_sync (
    .clk(clk), .rst_n(rst_n), .d(sdata_i), .q(sdata_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end
  assign rise = sclk_s & ~sclk_q;

  // a byte may only begin while the request line is asserted
  assign accept = rise & en & serial & (~idle | ~rts_n_o);

  sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(~en), .bit_stb(accept), .bit_val(sdata_s),
    .msb_first(msb_first), .idle(idle), .done_stb(complete), .byte_o(byte_w));

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; msb_first <= 1'b0; serial <= 1'b0;
    end else if (wr_ctrl) begin
      en        <= wdata[CB_EN];
      msb_first <= wdata[CB_MSB];
      serial    <= wdata[CB_SER];
    end
  end

  // flags, buffer and request line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      rx_done  <= 1'b0;
      overrun  <= 1'b0;
      irq_o    <= 1'b0;
      rts_n_o  <= 1'b1;
      rx_buf   <= '0;
    end else begin
      if (wr_txb)        tx_empty <= 1'b0;
      else if (complete) tx_empty <= 1'b1;

      if (!en)           rx_done <= 1'b0;
      else if (complete) rx_done <= 1'b1;
      else if (rd_rxb)   rx_done <= 1'b0;

      if (!en || !serial)           overrun <= 1'b0;
      else if (complete && rx_done) overrun <= 1'b1;

      if (complete && !rx_done)          irq_o <= 1'b1;
      else if (wr_stat && wdata[SB_IRQ]) irq_o <= 1'b0;

      if (!en)                   rts_n_o <= 1'b1;
      else if (accept && idle)   rts_n_o <= 1'b1;
      else if (!tx_empty && idle) rts_n_o <= 1'b0;

      if (complete) rx_buf <= byte_w;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(ADR_CTRL): begin
        rdata[CB_EN]  = en;
        rdata[CB_MSB] = msb_first;
        rdata[CB_SER] = serial;
      end
      ADDR_W'(ADR_RXB): rdata = rx_buf;
      ADDR_W'(ADR_STAT): begin
        rdata[SB_DONE] = rx_done;
        rdata[SB_OVR]  = overrun;
        rdata[SB_TXE]  = tx_empty;
        rdata[SB_IRQ]  = irq_o;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/sync_rx_checker.sv
module sync_rx_checker #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rts_n_o,
  input logic              irq_o,
  input logic              en,
  input logic              serial,
  input logic              tx_empty,
  input logic              rx_done,
  input logic              overrun
);
  AST_RTS_NEEDS_TX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n_o) |-> $past(en && !tx_empty)); // R3

  AST_RTS_HIGH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> rts_n_o); // R2

  AST_IRQ_ON_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $rose(rx_done)); // R6

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(rx_done) && rx_done)); // R7

  AST_DONE_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_done) |-> $past(!en || (rd_en && addr == ADDR_W'(2)))); // R8

  AST_OVR_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(!en || !serial)); // R9
endmodule

bind sync_rx_port sync_rx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
  .rts_n_o(rts_n_o), .irq_o(irq_o), .en(en), .serial(serial),
  .tx_empty(tx_empty), .rx_done(rx_done), .overrun(overrun));

// File: tb/test_sync_rx_port.sv
`timescale 1ns/1ps
module test_sync_rx_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sclk_i = 1'b0, sdata_i = 1'b0;
  logic       rts_n_o, irq_o;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sync_rx_port i_sync_rx_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .rts_n_o(rts_n_o), .irq_o(irq_o));

  // behavioural reference model
  bit m_en, m_msb, m_ser, m_txe, m_done, m_ovr, m_irq, m_rts;
  bit [7:0] m_buf, m_asm;
  int m_cnt;
  bit c1, c2, c3, d1, d2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_msb = 0; m_ser = 0; m_txe = 1; m_done = 0; m_ovr = 0;
      m_irq = 0; m_rts = 1; m_buf = 0; m_asm = 0; m_cnt = 0;
      c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0;
    end else begin
      bit edge_seen, acc, fin, n_rts, n_done, n_ovr, n_irq, n_txe;
      bit [7:0] got;
      edge_seen = c2 && !c3;
      acc = edge_seen && m_en && m_ser && (m_cnt != 0 || !m_rts);
      fin = 0; got = 0;
      n_rts = m_rts;
      if (!m_en) n_rts = 1;
      else if (acc && m_cnt == 0) n_rts = 1;
      else if (!m_txe && m_cnt == 0) n_rts = 0;
      if (!m_en) m_cnt = 0;
      else if (acc) begin
        if (m_msb) m_asm[7 - m_cnt] = d2; else m_asm[m_cnt] = d2;
        if (m_cnt == 7) begin fin = 1; got = m_asm; m_cnt = 0; end
        else m_cnt++;
      end
      n_done = m_done;
      if (!m_en) n_done = 0;
      else if (fin) n_done = 1;
      else if (rd_en && addr == 2) n_done = 0;
      n_ovr = m_ovr;
      if (!m_en || !m_ser) n_ovr = 0;
      else if (fin && m_done) n_ovr = 1;
      n_irq = m_irq;
      if (fin && !m_done) n_irq = 1;
      else if (wr_en && addr == 3 && wdata[6]) n_irq = 0;
      n_txe = m_txe;
      if (wr_en && addr == 1) n_txe = 0;
      else if (fin) n_txe = 1;
      if (fin) m_buf = got;
      if (wr_en && addr == 0) begin m_en = wdata[0]; m_msb = wdata[1]; m_ser = wdata[2]; end
      m_rts = n_rts; m_done = n_done; m_ovr = n_ovr; m_irq = n_irq; m_txe = n_txe;
      c3 = c2; c2 = c1; c1 = sclk_i; d2 = d1; d1 = sdata_i;
    end
  end

  function automatic bit [7:0] model_rdata(bit [1:0] a);
    case (a)
      2'd0: return {5'd0, m_ser, m_msb, m_en};
      2'd2: return m_buf;
      2'd3: return {1'b0, m_irq, m_txe, 3'b000, m_ovr, m_done};
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    check("R3 rts_n per-cycle", {7'd0, rts_n_o}, {7'd0, m_rts});
    check("R6 irq per-cycle", {7'd0, irq_o}, {7'd0, m_irq});
    check("R5 rdata per-cycle", rdata, model_rdata(addr));
  end

  task automatic wr(bit [1:0] a, bit [7:0] d);
    @(negedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(bit [1:0] a, output logic [7:0] v);
    @(negedge clk); #1; rd_en = 1; addr = a;
    #2 v = rdata;
    @(negedge clk); #1; rd_en = 0;
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); #1; sdata_i = b; sclk_i = 0;
    repeat (4) @(negedge clk);
    #1 sclk_i = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_seq(bit [7:0] s, int n);
    for (int i = 0; i < n; i++) send_bit(s[i]);
    repeat (6) @(negedge clk);
  endtask

  function automatic bit [7:0] rev(bit [7:0] x);
    bit [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 rts_n", {7'd0, rts_n_o}, 8'd1);
    check("R1 irq", {7'd0, irq_o}, 8'd0);
    rd(2'd3, v); check("R1 status", v, 8'h20);
    rd(2'd0, v); check("R1 control", v, 8'h00);
    // R2: serial mode but disabled
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h00);
    send_seq(8'hA5, 8);
    rd(2'd3, v); check("R2 no byte while disabled", v & 8'h01, 8'h00);
    check("R2 rts high while disabled", {7'd0, rts_n_o}, 8'd1);
    // R3: edge ignored while rts high (tx_empty still set after reset? cleared above)
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    repeat (3) @(negedge clk);
    check("R3 rts low after enable and tx write", {7'd0, rts_n_o}, 8'd0);
    rd(2'd3, v); check("R4 tx_empty cleared", v & 8'h20, 8'h00);
    send_bit(1'b1);
    repeat (2) @(negedge clk);
    check("R3 rts high once a byte starts", {7'd0, rts_n_o}, 8'd1);
    send_seq(8'h9E, 7);  // first bit 1 already sent: full seq 0x3D
    rd(2'd2, v); check("R5 R10 lsb-first byte", v, 8'h3D);
    check("R6 irq after byte", {7'd0, irq_o}, 8'd1);
    // the read just cleared done; tx_empty set again
    rd(2'd3, v); check("R4 R8 status after read", v & 8'h63, 8'h60);
    // R3: with tx_empty set, an edge is ignored
    send_seq(8'hFF, 1);
    rd(2'd3, v); check("R3 ignored edge while rts high", v & 8'h01, 8'h00);
    // R7: two bytes without a read
    wr(2'd3, 8'h40);
    check("R6 irq acknowledged", {7'd0, irq_o}, 8'd0);
    wr(2'd1, 8'h00); repeat (3) @(negedge clk);
    send_seq(8'h11, 8);
    wr(2'd1, 8'h00); repeat (3) @(negedge clk);
    send_seq(8'hC3, 8);
    rd(2'd3, v); check("R7 overrun set", v & 8'h03, 8'h03);
    check("R11 async error bits zero", v & 8'h1C, 8'h00);
    check("R6 irq held", {7'd0, irq_o}, 8'd1);
    rd(2'd2, v); check("R5 latest byte kept", v, 8'hC3);
    rd(2'd3, v); check("R9 overrun survives read", v & 8'h03, 8'h02);
    // R9: switching order keeps overrun, parallel mode clears it
    wr(2'd0, 8'h07);
    rd(2'd3, v); check("R9 overrun kept in serial", v & 8'h02, 8'h02);
    wr(2'd0, 8'h03);
    rd(2'd3, v); check("R9 overrun cleared by parallel", v & 8'h02, 8'h00);
    // R10: msb-first
    wr(2'd0, 8'h07);
    wr(2'd3, 8'h40);
    wr(2'd1, 8'h00); repeat (3) @(negedge clk);
    send_seq(8'h2B, 8);
    rd(2'd2, v); check("R10 msb-first byte", v, rev(8'h2B));
    // R8: disable clears done
    wr(2'd1, 8'h00); repeat (3) @(negedge clk);
    send_seq(8'h5A, 8);
    rd(2'd3, v); check("R8 done before disable", v & 8'h01, 8'h01);
    wr(2'd0, 8'h06);
    rd(2'd3, v); check("R8 done cleared by disable", v & 8'h03, 8'h00);
    // R12: partial byte discarded
    wr(2'd3, 8'h40);
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00); repeat (3) @(negedge clk);
    send_seq(8'h07, 3);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h05);
    repeat (3) @(negedge clk);
    send_seq(8'h96, 8);
    rd(2'd2, v); check("R12 fresh byte after abort", v, 8'h96);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule